// File: doc/BRIEF.md
# Half-Rate DDR Command Launcher

This block sits between a DDR SDRAM memory controller that runs at half the memory clock rate and the double-data-rate output registers of the address and command pins. Each half-rate clock period covers two memory clock cycles. For every output the block produces a pair of bits: a high slot, sent on the rising edge of the half-rate clock and so in the first memory cycle, and a low slot, sent on the falling edge and so in the second memory cycle.

Per command the controller gives the command bits, address, bank, target rank, an on-die-termination request and a slot choice. Chip select and ODT of the chosen rank are asserted in one slot only, so they last one memory cycle. Address, bank and the RAS/CAS/WE command bits are driven in both slots, so they stay valid for two memory cycles (2T timing). Built with `FULL_RATE = 1`, the block skips the slot conversion: its clock then runs at the memory clock rate and both slots carry the same value, so every signal lasts the whole cycle.

Top module: `ddr_cmd_slotter`

## Requirements
- R1: All outputs are registered. A command presented with `cmd_valid` high at one rising edge of `clk` shows up at the outputs right after that edge, one clock of latency, and every hi/lo pair changes in the same cycle.
- R2: In half-rate mode the `cs_n` bit of the addressed rank is low in exactly one of its two slots for each command. No rank ever has `cs_n` low in both slots.
- R3: For a command, the address, the bank and the command bits `{ras_n, cas_n, we_n}` are equal in the high slot and the low slot.
- R4: `cmd_slot_lo` = 0 puts chip select in the high (rising-edge, first) slot. `cmd_slot_lo` = 1 puts it in the low (falling-edge, second) slot. The other slot drives `cs_n` high.
- R5: With `cmd_odt` = 1, the addressed rank's ODT bit is high in the same slot or slots as its chip select. In every other slot and for every other rank, ODT is low.
- R6: A cycle with `cmd_valid` = 0 drives a NOP into both slots: all `cs_n` high, `ras_n`/`cas_n`/`we_n` high, all ODT low, and address and bank zero.
- R7: `cmd_rank` is a binary rank index, and bit k of `cs_n_*`/`odt_*` belongs to rank k. Only the addressed rank's bit may be asserted, and at most one `cs_n` bit is low in each slot.
- R8: A synchronous, active-high `rst` forces the NOP state of R6 into both slots, with ODT low and both CKE slots at the `CKE_RST` parameter value. This holds even when a command is presented at the same time.
- R9: Outside reset, `cke_in` is copied into both CKE slots with the latency of R1.
- R10: With `FULL_RATE` = 1, every slot pair carries identical values. The addressed rank's `cs_n` and ODT are asserted in both slots, and `cmd_slot_lo` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock (memory clock rate when FULL_RATE = 1) |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued in this cycle |
| cmd_ras_n | input | 1 | RAS_n value of the command |
| cmd_cas_n | input | 1 | CAS_n value of the command |
| cmd_we_n | input | 1 | WE_n value of the command |
| cmd_addr | input | ADDR_W | Row/column address |
| cmd_bank | input | BANK_W | Bank address |
| cmd_rank | input | RANK_W | Binary index of the target rank |
| cmd_odt | input | 1 | Assert ODT on the target rank with chip select |
| cmd_slot_lo | input | 1 | 0: chip select in high slot, 1: in low slot |
| cke_in | input | 1 | Clock-enable level to drive |
| cs_n_hi | output | RANKS | Chip selects, high (first) slot, active low |
| cs_n_lo | output | RANKS | Chip selects, low (second) slot, active low |
| odt_hi | output | RANKS | ODT per rank, high slot |
| odt_lo | output | RANKS | ODT per rank, low slot |
| ras_n_hi | output | 1 | RAS_n, high slot |
| ras_n_lo | output | 1 | RAS_n, low slot |
| cas_n_hi | output | 1 | CAS_n, high slot |
| cas_n_lo | output | 1 | CAS_n, low slot |
| we_n_hi | output | 1 | WE_n, high slot |
| we_n_lo | output | 1 | WE_n, low slot |
| addr_hi | output | ADDR_W | Address, high slot |
| addr_lo | output | ADDR_W | Address, low slot |
| bank_hi | output | BANK_W | Bank, high slot |
| bank_lo | output | BANK_W | Bank, low slot |
| cke_hi | output | 1 | CKE, high slot |
| cke_lo | output | 1 | CKE, low slot |

## Verification
The assertions assume that the inputs are steady around each rising clock edge, and that `cmd_rank` is below `RANKS` whenever `cmd_valid` is high. The one-slot and one-rank properties rest on these two assumptions. The bench changes every input on the falling edge only. It draws ranks from 0 to `RANKS`-1 and uses `RANKS` = 4, so the two-bit rank field has no out-of-range code. Its random phase still mixes idle cycles, back-to-back commands, both slot choices, both ODT values and toggling CKE, and it applies a reset in the middle of the run while a command is held on the inputs.

// File: rtl/ddr_slot_pkg.sv
package ddr_slot_pkg;

  // Slot choice for chip select and ODT inside one half-rate period
  typedef enum logic {
    SLOT_RISE = 1'b0,
    SLOT_FALL = 1'b1
  } slot_e;

  // {ras_n, cas_n, we_n} for a no-operation cycle
  localparam logic [2:0] CMD_NOP = 3'b111;

  // Command bits to launch: the request when valid, otherwise NOP
  function automatic logic [2:0] gate_cmd(input logic valid, input logic ras_n,
                                          input logic cas_n, input logic we_n);
    return valid ? {ras_n, cas_n, we_n} : CMD_NOP;
  endfunction

  // Whether the selected rank is driven in a given slot
  function automatic logic slot_hit(input logic full_rate, input slot_e pick,
                                    input slot_e this_slot);
    return full_rate || (pick == this_slot);
  endfunction

endpackage

// File: rtl/ddr_cmd_gate.sv
module ddr_cmd_gate #(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              valid,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  output logic [2:0]        cmd_bits,
  output logic [ADDR_W-1:0] addr_out,
  output logic [BANK_W-1:0] bank_out
);
  import ddr_slot_pkg::*;

  always_comb begin
    cmd_bits = gate_cmd(valid, ras_n, cas_n, we_n);
    addr_out = valid ? addr : '0;
    bank_out = valid ? bank : '0;
  end
endmodule

// File: rtl/ddr_rank_slot.sv
module ddr_rank_slot #(
  parameter int RANKS     = 2,
  parameter bit FULL_RATE = 1'b0,
  localparam int RANK_W   = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic              valid,
  input  logic [RANK_W-1:0] rank,
  input  logic              odt,
  input  logic              slot_lo,
  output logic [RANKS-1:0]  sel_hi,
  output logic [RANKS-1:0]  sel_lo,
  output logic [RANKS-1:0]  odt_hi,
  output logic [RANKS-1:0]  odt_lo
);
  import ddr_slot_pkg::*;

  logic [RANKS-1:0] rank_hit;
  logic             use_hi;
  logic             use_lo;
  slot_e            pick;

  for (genvar k = 0; k < RANKS; k++) begin : g_rank
    assign rank_hit[k] = valid && (rank == RANK_W'(k));
  end

  assign pick = slot_e'(slot_lo);

  if (FULL_RATE) begin : g_full
    // No slot conversion: the command fills the whole memory cycle
    assign use_hi = slot_hit(1'b1, pick, SLOT_RISE);
    assign use_lo = slot_hit(1'b1, pick, SLOT_FALL);
  end else begin : g_half
    assign use_hi = slot_hit(1'b0, pick, SLOT_RISE);
    assign use_lo = slot_hit(1'b0, pick, SLOT_FALL);
  end

  always_comb begin
    sel_hi = use_hi ? rank_hit : '0;
    sel_lo = use_lo ? rank_hit : '0;
    odt_hi = sel_hi & {RANKS{odt}};
    odt_lo = sel_lo & {RANKS{odt}};
  end
endmodule

// File: rtl/ddr_slot_regs.sv
module ddr_slot_regs #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/ddr_cmd_slotter.sv
module ddr_cmd_slotter #(
  parameter int   ADDR_W    = 14,
  parameter int   BANK_W    = 3,
  parameter int   RANKS     = 2,
  parameter bit   FULL_RATE = 1'b0,
  parameter logic CKE_RST   = 1'b0,
  localparam int  RANK_W    = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_ras_n,
  input  logic              cmd_cas_n,
  input  logic              cmd_we_n,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [RANK_W-1:0] cmd_rank,
  input  logic              cmd_odt,
  input  logic              cmd_slot_lo,
  input  logic              cke_in,
  output logic [RANKS-1:0]  cs_n_hi,
  output logic [RANKS-1:0]  cs_n_lo,
  output logic [RANKS-1:0]  odt_hi,
  output logic [RANKS-1:0]  odt_lo,
  output logic              ras_n_hi,
  output logic              ras_n_lo,
  output logic              cas_n_hi,
  output logic              cas_n_lo,
  output logic              we_n_hi,
  output logic              we_n_lo,
  output logic [ADDR_W-1:0] addr_hi,
  output logic [ADDR_W-1:0] addr_lo,
  output logic [BANK_W-1:0] bank_hi,
  output logic [BANK_W-1:0] bank_lo,
  output logic              cke_hi,
  output logic              cke_lo
);
  import ddr_slot_pkg::*;

  // Slot word layout: {cke, cs_n, odt, ras_n/cas_n/we_n, bank, addr}
  localparam int VEC_W = 1 + 2 * RANKS + 3 + BANK_W + ADDR_W;
  localparam logic [VEC_W-1:0] RST_VEC =
    {CKE_RST, {RANKS{1'b1}}, {RANKS{1'b0}}, CMD_NOP, {BANK_W{1'b0}}, {ADDR_W{1'b0}}};

  // Named events for the checker
  logic cmd_fire;
  logic cs_in_fall;
  assign cmd_fire   = cmd_valid;
  assign cs_in_fall = cmd_slot_lo;

  logic [2:0]        cmd_bits;
  logic [ADDR_W-1:0] addr_g;
  logic [BANK_W-1:0] bank_g;
  logic [RANKS-1:0]  sel_hi, sel_lo, odt_sel_hi, odt_sel_lo;

  ddr_cmd_gate #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_gate (
    .valid    (cmd_fire),
    .ras_n    (cmd_ras_n),
    .cas_n    (cmd_cas_n),
    .we_n     (cmd_we_n),
    .addr     (cmd_addr),
    .bank     (cmd_bank),
    .cmd_bits (cmd_bits),
    .addr_out (addr_g),
    .bank_out (bank_g)
  );

  ddr_rank_slot #(.RANKS(RANKS), .FULL_RATE(FULL_RATE)) u_rank (
    .valid   (cmd_fire),
    .rank    (cmd_rank),
    .odt     (cmd_odt),
    .slot_lo (cs_in_fall),
    .sel_hi  (sel_hi),
    .sel_lo  (sel_lo),
    .odt_hi  (odt_sel_hi),
    .odt_lo  (odt_sel_lo)
  );

  logic [VEC_W-1:0] d_hi, d_lo, q_hi, q_lo;
  assign d_hi = {cke_in, ~sel_hi, odt_sel_hi, cmd_bits, bank_g, addr_g};
  assign d_lo = {cke_in, ~sel_lo, odt_sel_lo, cmd_bits, bank_g, addr_g};

  ddr_slot_regs #(.W(VEC_W), .RST_VAL(RST_VEC)) u_regs_hi (
    .clk (clk), .rst (rst), .d (d_hi), .q (q_hi)
  );
  ddr_slot_regs #(.W(VEC_W), .RST_VAL(RST_VEC)) u_regs_lo (
    .clk (clk), .rst (rst), .d (d_lo), .q (q_lo)
  );

  assign {cke_hi, cs_n_hi, odt_hi, ras_n_hi, cas_n_hi, we_n_hi, bank_hi, addr_hi} = q_hi;
  assign {cke_lo, cs_n_lo, odt_lo, ras_n_lo, cas_n_lo, we_n_lo, bank_lo, addr_lo} = q_lo;
endmodule

// File: rtl/ddr_cmd_slotter_chk.sv
module ddr_cmd_slotter_chk #(
  parameter int   ADDR_W    = 14,
  parameter int   BANK_W    = 3,
  parameter int   RANKS     = 2,
  parameter bit   FULL_RATE = 1'b0,
  parameter logic CKE_RST   = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              fire,
  input logic              slot_fall,
  input logic              cke_in,
  input logic [RANKS-1:0]  cs_n_hi,
  input logic [RANKS-1:0]  cs_n_lo,
  input logic [RANKS-1:0]  odt_hi,
  input logic [RANKS-1:0]  odt_lo,
  input logic              ras_n_hi,
  input logic              ras_n_lo,
  input logic              cas_n_hi,
  input logic              cas_n_lo,
  input logic              we_n_hi,
  input logic              we_n_lo,
  input logic [ADDR_W-1:0] addr_hi,
  input logic [ADDR_W-1:0] addr_lo,
  input logic [BANK_W-1:0] bank_hi,
  input logic [BANK_W-1:0] bank_lo,
  input logic              cke_hi,
  input logic              cke_lo
);
  a_r1_issue_latency: assert property (@(posedge clk) disable iff (rst)
    fire |=> (($countones(~cs_n_hi) + $countones(~cs_n_lo)) != 0));

  a_r3_both_slots_same: assert property (@(posedge clk) disable iff (rst)
    (addr_hi == addr_lo) && (bank_hi == bank_lo) &&
    (ras_n_hi == ras_n_lo) && (cas_n_hi == cas_n_lo) && (we_n_hi == we_n_lo));

  a_r5_odt_with_cs: assert property (@(posedge clk) disable iff (rst)
    ((odt_hi & cs_n_hi) == '0) && ((odt_lo & cs_n_lo) == '0));

  a_r6_idle_nop: assert property (@(posedge clk) disable iff (rst)
    !fire |=> (&cs_n_hi) && (&cs_n_lo) && ras_n_hi && cas_n_hi && we_n_hi &&
              (odt_hi == '0) && (odt_lo == '0));

  a_r7_one_rank: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n_hi) && $onehot0(~cs_n_lo));

  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> (&cs_n_hi) && (&cs_n_lo) && (odt_hi == '0) && (odt_lo == '0) &&
            (cke_hi == CKE_RST) && (cke_lo == CKE_RST));

  a_r9_cke_copy: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cke_hi == $past(cke_in)) && (cke_lo == $past(cke_in)));

  if (FULL_RATE) begin : g_full_chk
    a_r10_full_slots_equal: assert property (@(posedge clk) disable iff (rst)
      (cs_n_hi == cs_n_lo) && (odt_hi == odt_lo));
  end else begin : g_half_chk
    a_r2_single_slot: assert property (@(posedge clk) disable iff (rst)
      ((~cs_n_hi) & (~cs_n_lo)) == '0);
    a_r4_rise_slot: assert property (@(posedge clk) disable iff (rst)
      (fire && !slot_fall) |=> (&cs_n_lo));
    a_r4_fall_slot: assert property (@(posedge clk) disable iff (rst)
      (fire && slot_fall) |=> (&cs_n_hi));
  end
endmodule

bind ddr_cmd_slotter ddr_cmd_slotter_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .RANKS(RANKS),
  .FULL_RATE(FULL_RATE), .CKE_RST(CKE_RST)
) i_chk (
  .clk(clk), .rst(rst), .fire(cmd_fire), .slot_fall(cs_in_fall), .cke_in(cke_in),
  .cs_n_hi(cs_n_hi), .cs_n_lo(cs_n_lo), .odt_hi(odt_hi), .odt_lo(odt_lo),
  .ras_n_hi(ras_n_hi), .ras_n_lo(ras_n_lo), .cas_n_hi(cas_n_hi), .cas_n_lo(cas_n_lo),
  .we_n_hi(we_n_hi), .we_n_lo(we_n_lo), .addr_hi(addr_hi), .addr_lo(addr_lo),
  .bank_hi(bank_hi), .bank_lo(bank_lo), .cke_hi(cke_hi), .cke_lo(cke_lo)
);

// File: tb/test_ddr_cmd_slotter.sv
`timescale 1ns/1ps
module test_ddr_cmd_slotter;
  localparam int   A  = 14;
  localparam int   B  = 3;
  localparam int   R  = 4;
  localparam int   RW = 2;
  localparam logic CK_RST = 1'b0;

  typedef struct packed {
    logic         cke_hi, cke_lo;
    logic [R-1:0] cs_hi, cs_lo, odt_hi, odt_lo;
    logic [2:0]   cmd_hi, cmd_lo;
    logic [B-1:0] bank_hi, bank_lo;
    logic [A-1:0] addr_hi, addr_lo;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, valid = 1'b0, ras = 1'b1, cas = 1'b1, we = 1'b1;
  logic odt = 1'b0, slot = 1'b0, cke = 1'b0;
  logic [A-1:0] addr = '0;
  logic [B-1:0] bank = '0;
  logic [RW-1:0] rank = '0;

  exp_t act_h, act_f;
  logic [R-1:0] h_csh, h_csl, h_oh, h_ol, f_csh, f_csl, f_oh, f_ol;
  logic h_rh, h_rl, h_ch, h_cl, h_wh, h_wl, h_kh, h_kl;
  logic f_rh, f_rl, f_ch, f_cl, f_wh, f_wl, f_kh, f_kl;
  logic [A-1:0] h_ah, h_al, f_ah, f_al;
  logic [B-1:0] h_bh, h_bl, f_bh, f_bl;

  ddr_cmd_slotter #(.ADDR_W(A), .BANK_W(B), .RANKS(R), .FULL_RATE(1'b0), .CKE_RST(CK_RST))
  i_ddr_cmd_slotter (
    .clk(clk), .rst(rst), .cmd_valid(valid), .cmd_ras_n(ras), .cmd_cas_n(cas),
    .cmd_we_n(we), .cmd_addr(addr), .cmd_bank(bank), .cmd_rank(rank), .cmd_odt(odt),
    .cmd_slot_lo(slot), .cke_in(cke),
    .cs_n_hi(h_csh), .cs_n_lo(h_csl), .odt_hi(h_oh), .odt_lo(h_ol),
    .ras_n_hi(h_rh), .ras_n_lo(h_rl), .cas_n_hi(h_ch), .cas_n_lo(h_cl),
    .we_n_hi(h_wh), .we_n_lo(h_wl), .addr_hi(h_ah), .addr_lo(h_al),
    .bank_hi(h_bh), .bank_lo(h_bl), .cke_hi(h_kh), .cke_lo(h_kl));

  ddr_cmd_slotter #(.ADDR_W(A), .BANK_W(B), .RANKS(R), .FULL_RATE(1'b1), .CKE_RST(CK_RST))
  i_ddr_cmd_slotter_fr (
    .clk(clk), .rst(rst), .cmd_valid(valid), .cmd_ras_n(ras), .cmd_cas_n(cas),
    .cmd_we_n(we), .cmd_addr(addr), .cmd_bank(bank), .cmd_rank(rank), .cmd_odt(odt),
    .cmd_slot_lo(slot), .cke_in(cke),
    .cs_n_hi(f_csh), .cs_n_lo(f_csl), .odt_hi(f_oh), .odt_lo(f_ol),
    .ras_n_hi(f_rh), .ras_n_lo(f_rl), .cas_n_hi(f_ch), .cas_n_lo(f_cl),
    .we_n_hi(f_wh), .we_n_lo(f_wl), .addr_hi(f_ah), .addr_lo(f_al),
    .bank_hi(f_bh), .bank_lo(f_bl), .cke_hi(f_kh), .cke_lo(f_kl));

  assign act_h = '{h_kh, h_kl, h_csh, h_csl, h_oh, h_ol, {h_rh, h_ch, h_wh},
                   {h_rl, h_cl, h_wl}, h_bh, h_bl, h_ah, h_al};
  assign act_f = '{f_kh, f_kl, f_csh, f_csl, f_oh, f_ol, {f_rh, f_ch, f_wh},
                   {f_rl, f_cl, f_wl}, f_bh, f_bl, f_ah, f_al};

  int checks = 0, errors = 0;
  bit done = 1'b0;
  exp_t q_half[$], q_full[$];

  // Expected slot pair built from the requirements
  function automatic exp_t build(input bit full);
    exp_t e;
    e.cke_hi = rst ? CK_RST : cke;                        // R8, R9
    e.cke_lo = e.cke_hi;
    e.cs_hi = '1; e.cs_lo = '1; e.odt_hi = '0; e.odt_lo = '0;
    e.cmd_hi = 3'b111; e.cmd_lo = 3'b111;                 // R6 NOP
    e.bank_hi = '0; e.bank_lo = '0; e.addr_hi = '0; e.addr_lo = '0;
    if (!rst && valid) begin
      e.cmd_hi = {ras, cas, we}; e.cmd_lo = e.cmd_hi;     // R3
      e.bank_hi = bank; e.bank_lo = bank;
      e.addr_hi = addr; e.addr_lo = addr;
      if (full || !slot) begin e.cs_hi[rank] = 1'b0; e.odt_hi[rank] = odt; end  // R4, R7, R10
      if (full || slot)  begin e.cs_lo[rank] = 1'b0; e.odt_lo[rank] = odt; end
    end
    return e;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string mode, input exp_t a, input exp_t e, input bit full);
    string cs_req;
    cs_req = full ? "R10" : "R2/R4/R7";
    chk(cs_req, {mode, " cs_n hi"}, 64'(a.cs_hi), 64'(e.cs_hi));
    chk(cs_req, {mode, " cs_n lo"}, 64'(a.cs_lo), 64'(e.cs_lo));
    chk("R5", {mode, " odt"}, 64'({a.odt_hi, a.odt_lo}), 64'({e.odt_hi, e.odt_lo}));
    chk("R3", {mode, " cmd"}, 64'({a.cmd_hi, a.cmd_lo}), 64'({e.cmd_hi, e.cmd_lo}));
    chk("R3", {mode, " addr/bank"}, 64'({a.bank_hi, a.bank_lo, a.addr_hi, a.addr_lo}),
        64'({e.bank_hi, e.bank_lo, e.addr_hi, e.addr_lo}));
    chk("R9", {mode, " cke"}, 64'({a.cke_hi, a.cke_lo}), 64'({e.cke_hi, e.cke_lo}));
  endtask

  // Driver: inputs change on the falling edge; expected result queued
  task automatic step(input logic r, input logic v, input logic [RW-1:0] rk,
                      input logic s, input logic o, input logic [2:0] c,
                      input logic [B-1:0] b, input logic [A-1:0] ad, input logic k);
    @(negedge clk);
    rst = r; valid = v; rank = rk; slot = s; odt = o;
    {ras, cas, we} = c; bank = b; addr = ad; cke = k;
    q_half.push_back(build(1'b0));
    q_full.push_back(build(1'b1));
  endtask

  // Monitor: R1 one-cycle latency, each queued item is due after the next rising edge
  always @(posedge clk) begin
    #1;
    if (q_half.size() > 0) compare("half", act_h, q_half.pop_front(), 1'b0);
    if (q_full.size() > 0) compare("full", act_f, q_full.pop_front(), 1'b1);
  end

  initial begin
    // R8: reset state
    step(1, 0, 0, 0, 0, 3'b111, 0, 0, 0);
    step(1, 1, 2, 1, 1, 3'b010, 3, 14'h1234, 1);
    // R6: idle
    step(0, 0, 3, 1, 1, 3'b000, 5, 14'h3fff, 1);
    // R4 high slot, R7 rank 0
    step(0, 1, 0, 0, 0, 3'b011, 1, 14'h0abc, 1);
    // R4 low slot, R5 odt on rank 1
    step(0, 1, 1, 1, 1, 3'b100, 7, 14'h3fff, 1);
    // R7 top rank, high slot with odt
    step(0, 1, 3, 0, 1, 3'b101, 0, 14'h0001, 1);
    step(0, 1, 2, 1, 0, 3'b110, 2, 14'h0000, 0);
    step(0, 0, 0, 0, 0, 3'b111, 0, 0, 0);
    // R8: reset while a command is held
    step(0, 1, 1, 0, 1, 3'b001, 4, 14'h2222, 1);
    step(1, 1, 1, 0, 1, 3'b001, 4, 14'h2222, 1);
    step(0, 1, 3, 1, 1, 3'b000, 6, 14'h1555, 1);
    for (int i = 0; i < 400; i++) begin
      step(0, 1'($urandom_range(0, 1)), RW'($urandom_range(0, R - 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 3'($urandom),
           B'($urandom), A'($urandom), 1'($urandom_range(0, 1)));
    end
    step(0, 0, 0, 0, 0, 3'b111, 0, 0, 1);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule